// File: doc/BRIEF.md
# Power-Up Soft-Start Sequencer

This block steps a primary-side flyback controller from supply turn-on to steady regulation. Once the supply-good flag rises it leaves its idle state and starts three tick-driven timers: one holds the high-voltage start-up bias on for a fixed span, one ramps a duty ceiling from zero to full scale, and one measures the time spent in each start-up phase. All timers advance only on a 1 µs tick input, so every span is a count of ticks.

The first phase opens with a window of reduced current limit and reduced switching frequency that keeps the converter out of continuous conduction. The first phase closes when the compensation-node comparator reports that the node has fallen below its threshold, or when a maximum time runs out. A settling phase follows. After settling, the block waits for the input-peak strobe and then a fixed delay, so that the loop hands over from proportional to integral gain near the low point of the compensation voltage. If no peak arrives within a timeout, the hand-over happens anyway. An under-voltage flag returns everything to idle at any time.

The phase code is brought out so that the power stage and test logic can follow the sequence. A one-clock done pulse marks the entry to steady state.

Top module: `soft_start_seq`

## Requirements
- R1: While `rst_n` is low, or on the clock after `uvlo` is high (uvlo takes priority over every other input), the block is in idle: `phase` = 0, every timer is cleared, `hv_bias_en` = 1, `duty_limit` = 0, `ilim_low` = `freq_low` = `gain_integral` = `done` = 0.
- R2: From idle the block enters the start phase (`phase` = 1) on the first clock at which `supply_on` is high. It stays in idle while `supply_on` is low.
- R3: `hv_bias_en` stays 1 for the first BIAS_TICKS ticks after the block leaves idle, then stays 0 until the block returns to idle.
- R4: `ilim_low` and `freq_low` are 1 exactly while `phase` = 1 and fewer than CCM_TICKS ticks have passed in that phase. Otherwise they are 0.
- R5: `duty_limit` equals floor(n·DUTY_MAX / RAMP_TICKS), where n is the number of ticks since the block left idle, saturating at n = RAMP_TICKS. DUTY_MAX = 2^DUTY_W − 1.
- R6: In phase 1, `comp_low` ends the phase on the next clock once at least CCM_TICKS ticks have passed in it. During the CCM window `comp_low` is ignored.
- R7: Phase 1 ends on the clock after its count reaches SS1_MAX_TICKS, even without `comp_low`.
- R8: The settling phase (`phase` = 2) lasts until SETTLE_TICKS ticks have passed in it. `peak_strobe` has no effect during it.
- R9: In the peak-wait phase (`phase` = 3), a `peak_strobe` moves the block to the delay phase (`phase` = 4) on the next clock. This holds even in the cycle the timeout expires. The delay phase ends after PEAK_DELAY_TICKS ticks.
- R10: If the peak-wait phase reaches PEAK_TIMEOUT_TICKS ticks without a strobe, the block goes straight to steady state (`phase` = 5).
- R11: `gain_integral` is 1 in steady state and 0 in all other phases.
- R12: `done` is 1 for exactly the first clock cycle in which `phase` = 5.
- R13: When `tick_1us` is low, no timer advances: phase, `duty_limit` and `hv_bias_en` hold.

A phase whose limit is L, with a tick every clock, lasts L+1 clock cycles. The extra cycle is the registered exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1us | input | 1 | One-cycle time-base tick, 1 µs |
| supply_on | input | 1 | Supply has passed its turn-on level |
| uvlo | input | 1 | Under-voltage lockout, synchronous return to idle |
| comp_low | input | 1 | Compensation node below its 4.5 V threshold |
| peak_strobe | input | 1 | Input-voltage peak detected, one cycle |
| hv_bias_en | output | 1 | High-voltage start-up bias enable |
| ilim_low | output | 1 | Select the reduced current limit |
| freq_low | output | 1 | Select the reduced switching frequency |
| duty_limit | output | DUTY_W | Soft-start duty ceiling |
| gain_integral | output | 1 | 1 = integral gain, 0 = proportional gain |
| phase | output | 3 | 0 idle, 1 start, 2 settle, 3 peak wait, 4 peak delay, 5 steady |
| done | output | 1 | One-cycle pulse on entry to steady state |

## Verification
Two pairs of events can coincide. The first pair is a peak strobe and the peak-wait timeout, which fall in the same cycle when the strobe is driven exactly at the last count of the wait phase. The first phase's comparator exit can also coincide with the close of the CCM window, when `comp_low` is held from the first cycle or rises exactly at the window's last count. The bench measures each phase length in clock cycles and compares it with L+1 worked out from the requirements. If the strobe wins, the delay phase appears. If the timeout wins, the block goes straight to steady state.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_START    = 3'd1,
    PH_SETTLE   = 3'd2,
    PH_PEAKWAIT = 3'd3,
    PH_PEAKDLY  = 3'd4,
    PH_STEADY   = 3'd5
  } phase_e;

  // Linear duty ceiling: top * ticks / span, saturating at top.
  function automatic int unsigned ramp_level(input int unsigned ticks,
                                             input int unsigned span,
                                             input int unsigned top);
    if (span == 0 || ticks >= span) return top;
    return (ticks * top) / span;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sseq_tick_timer.sv
module sseq_tick_timer #(
  parameter int unsigned LIMIT = 1000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (run && tick && !at_top) cnt <= cnt + W'(1);
  end

  // R13
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

  // R1
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/sseq_duty_ramp.sv
module sseq_duty_ramp #(
  parameter int unsigned RAMP_TICKS = 26000,
  parameter int unsigned DUTY_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  output logic [DUTY_W-1:0] duty_limit
);
  localparam int unsigned DUTY_MAX = (1 << DUTY_W) - 1;
  localparam int RW = $clog2(RAMP_TICKS + 1);

  logic [RW-1:0] ramp_cnt;

  sseq_tick_timer #(.LIMIT(RAMP_TICKS)) u_ramp_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .run  (run),
    .tick (tick),
    .cnt  (ramp_cnt)
  );

  assign duty_limit = DUTY_W'(sseq_pkg::ramp_level(32'(ramp_cnt), RAMP_TICKS, DUTY_MAX));

  // R5
  duty_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (duty_limit >= $past(duty_limit)));

endmodule

// File: rtl/sseq_phase_fsm.sv
module sseq_phase_fsm #(
  parameter int unsigned CCM_TICKS          = 2000,
  parameter int unsigned SS1_MAX_TICKS      = 100000,
  parameter int unsigned SETTLE_TICKS       = 45000,
  parameter int unsigned PEAK_DELAY_TICKS   = 1500,
  parameter int unsigned PEAK_TIMEOUT_TICKS = 20000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  uvlo,
  input  logic                  tick,
  input  logic                  supply_on,
  input  logic                  comp_low,
  input  logic                  peak_strobe,
  output sseq_pkg::phase_e      phase,
  output logic                  ccm_win,
  output logic                  done
);
  import sseq_pkg::*;

  localparam int unsigned PH_LIMIT =
    max2(max2(SS1_MAX_TICKS, SETTLE_TICKS), max2(PEAK_DELAY_TICKS, PEAK_TIMEOUT_TICKS));
  localparam int PW = $clog2(PH_LIMIT + 1);
  localparam logic [PW-1:0] L_CCM    = PW'(CCM_TICKS);
  localparam logic [PW-1:0] L_SS1MAX = PW'(SS1_MAX_TICKS);
  localparam logic [PW-1:0] L_SETTLE = PW'(SETTLE_TICKS);
  localparam logic [PW-1:0] L_PKDLY  = PW'(PEAK_DELAY_TICKS);
  localparam logic [PW-1:0] L_PKTO   = PW'(PEAK_TIMEOUT_TICKS);

  phase_e         phase_q, phase_nxt;
  logic [PW-1:0]  ph_cnt;
  logic           done_q;

  // Named internal events
  logic start_exit_comp, start_exit_cap, settle_over, peak_seen, peak_timeout, delay_over;

  assign start_exit_comp = (phase_q == PH_START)    && comp_low && (ph_cnt >= L_CCM);
  assign start_exit_cap  = (phase_q == PH_START)    && (ph_cnt >= L_SS1MAX);
  assign settle_over     = (phase_q == PH_SETTLE)   && (ph_cnt >= L_SETTLE);
  assign peak_seen       = (phase_q == PH_PEAKWAIT) && peak_strobe;
  assign peak_timeout    = (phase_q == PH_PEAKWAIT) && (ph_cnt >= L_PKTO);
  assign delay_over      = (phase_q == PH_PEAKDLY)  && (ph_cnt >= L_PKDLY);

  always_comb begin
    phase_nxt = phase_q;
    if (uvlo) begin
      phase_nxt = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:     if (supply_on) phase_nxt = PH_START;
        PH_START:    if (start_exit_comp || start_exit_cap) phase_nxt = PH_SETTLE;
        PH_SETTLE:   if (settle_over) phase_nxt = PH_PEAKWAIT;
        PH_PEAKWAIT: begin
          if (peak_seen)         phase_nxt = PH_PEAKDLY;
          else if (peak_timeout) phase_nxt = PH_STEADY;
        end
        PH_PEAKDLY:  if (delay_over) phase_nxt = PH_STEADY;
        PH_STEADY:   phase_nxt = PH_STEADY;
        default:     phase_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      done_q  <= (phase_nxt == PH_STEADY) && (phase_q != PH_STEADY);
    end
  end

  sseq_tick_timer #(.LIMIT(PH_LIMIT)) u_phase_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (uvlo || (phase_nxt != phase_q)),
    .run  (phase_q != PH_IDLE),
    .tick (tick),
    .cnt  (ph_cnt)
  );

  assign phase   = phase_q;
  assign ccm_win = (phase_q == PH_START) && (ph_cnt < L_CCM);
  assign done    = done_q;

  // R1
  uvlo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (phase_q == PH_IDLE && ph_cnt == '0));

  // R6
  ccm_ignore_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_START && ph_cnt < L_CCM && !uvlo) |=> (phase_q == PH_START));

  // R7
  start_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_START) |-> (ph_cnt <= L_SS1MAX));

  // R8
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE && ph_cnt < L_SETTLE && !uvlo) |=> (phase_q == PH_SETTLE));

  // R9
  peak_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PEAKWAIT && peak_strobe && !uvlo) |=> (phase_q == PH_PEAKDLY));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R12
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_STEADY && $past(phase_q) != PH_STEADY));

endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
  parameter int unsigned BIAS_TICKS         = 500000,
  parameter int unsigned CCM_TICKS          = 2000,
  parameter int unsigned RAMP_TICKS         = 26000,
  parameter int unsigned SS1_MAX_TICKS      = 100000,
  parameter int unsigned SETTLE_TICKS       = 45000,
  parameter int unsigned PEAK_DELAY_TICKS   = 1500,
  parameter int unsigned PEAK_TIMEOUT_TICKS = 20000,
  parameter int unsigned DUTY_W             = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              supply_on,
  input  logic              uvlo,
  input  logic              comp_low,
  input  logic              peak_strobe,
  output logic              hv_bias_en,
  output logic              ilim_low,
  output logic              freq_low,
  output logic [DUTY_W-1:0] duty_limit,
  output logic              gain_integral,
  output logic [2:0]        phase,
  output logic              done
);
  import sseq_pkg::*;

  localparam int BW = $clog2(BIAS_TICKS + 1);
  localparam logic [BW-1:0] L_BIAS = BW'(BIAS_TICKS);

  phase_e        ph;
  logic          ccm_win;
  logic          in_idle;
  logic          seq_clr;
  logic [BW-1:0] bias_cnt;

  sseq_phase_fsm #(
    .CCM_TICKS         (CCM_TICKS),
    .SS1_MAX_TICKS     (SS1_MAX_TICKS),
    .SETTLE_TICKS      (SETTLE_TICKS),
    .PEAK_DELAY_TICKS  (PEAK_DELAY_TICKS),
    .PEAK_TIMEOUT_TICKS(PEAK_TIMEOUT_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .uvlo       (uvlo),
    .tick       (tick_1us),
    .supply_on  (supply_on),
    .comp_low   (comp_low),
    .peak_strobe(peak_strobe),
    .phase      (ph),
    .ccm_win    (ccm_win),
    .done       (done)
  );

  assign in_idle = (ph == PH_IDLE);
  assign seq_clr = uvlo || in_idle;

  sseq_tick_timer #(.LIMIT(BIAS_TICKS)) u_bias_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (seq_clr),
    .run  (!in_idle),
    .tick (tick_1us),
    .cnt  (bias_cnt)
  );

  sseq_duty_ramp #(.RAMP_TICKS(RAMP_TICKS), .DUTY_W(DUTY_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (seq_clr),
    .run       (!in_idle),
    .tick      (tick_1us),
    .duty_limit(duty_limit)
  );

  assign hv_bias_en    = (bias_cnt < L_BIAS);
  assign ilim_low      = ccm_win;
  assign freq_low      = ccm_win;
  assign gain_integral = (ph == PH_STEADY);
  assign phase         = ph;

  // R3
  bias_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_bias_en) |-> (phase != 3'd0));

  // R3
  bias_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> hv_bias_en);

  // R11
  gain_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_integral) |-> ($past(phase) == 3'd3 || $past(phase) == 3'd4));

endmodule

// File: tb/soft_start_seq_tb.sv
`timescale 1ns/1ps
module soft_start_seq_tb;
  localparam int BIAS = 300, CCM = 20, RAMP = 64, S1MAX = 200;
  localparam int SETTLE = 100, PKDLY = 15, PKTO = 60, DW = 8, DMAX = 255;
  localparam int SETTLE_PK = 50;

  // columns: comp_at, peak_at, exp start len, exp wait len, exp delay len
  localparam int NROW = 5;
  localparam int TBL [NROW][5] = '{
    '{ 50, 10,  51, 11, 16},
    '{  5,  0,  21,  1, 16},
    '{ -1, -1, 201, 61,  0},
    '{ 20, 60,  21, 61, 16},
    '{199, 30, 200, 31, 16}
  };

  logic clk = 0, rst_n = 0, tick = 1, supply_on = 0, uvlo = 0, comp_low = 0, peak = 0;
  logic hv_bias_en, ilim_low, freq_low, gain_integral, done;
  logic [DW-1:0] duty_limit;
  logic [2:0] phase;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  soft_start_seq #(
    .BIAS_TICKS(BIAS), .CCM_TICKS(CCM), .RAMP_TICKS(RAMP), .SS1_MAX_TICKS(S1MAX),
    .SETTLE_TICKS(SETTLE), .PEAK_DELAY_TICKS(PKDLY), .PEAK_TIMEOUT_TICKS(PKTO), .DUTY_W(DW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .supply_on(supply_on), .uvlo(uvlo),
    .comp_low(comp_low), .peak_strobe(peak), .hv_bias_en(hv_bias_en), .ilim_low(ilim_low),
    .freq_low(freq_low), .duty_limit(duty_limit), .gain_integral(gain_integral),
    .phase(phase), .done(done)
  );

  function automatic int exp_duty(input int n);
    if (n >= RAMP) return DMAX;
    return (n * DMAX) / RAMP;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_row(input int r);
    int comp_at, peak_at, n, guard, j, ph;
    int len [8];
    int bad_ccm, bad_duty, bad_bias, bad_gain, bad_done;
    comp_at = TBL[r][0];
    peak_at = TBL[r][1];
    @(negedge clk); uvlo = 1; comp_low = 0; peak = 0;
    @(negedge clk); uvlo = 0;
    chk(phase == 0 && hv_bias_en && duty_limit == 0, "R1", "idle after uvlo pulse", phase, 0);
    foreach (len[k]) len[k] = 0;
    n = 0; guard = 0;
    bad_ccm = 0; bad_duty = 0; bad_bias = 0; bad_gain = 0; bad_done = 0;
    while (guard < 2000) begin
      @(negedge clk);
      guard++;
      ph = int'(phase);
      j = len[ph];
      if (ph != 0) begin
        if ((ilim_low !== (ph == 1 && j < CCM)) || (freq_low !== ilim_low)) bad_ccm++;
        if (int'(duty_limit) != exp_duty(n)) bad_duty++;
        if (hv_bias_en !== (n < BIAS)) bad_bias++;
        if (gain_integral !== (ph == 5)) bad_gain++;
        if (done !== (ph == 5 && j == 0)) bad_done++;
        n++;
      end
      comp_low = (ph == 1 && comp_at >= 0 && j >= comp_at);
      peak = (ph == 2 && j == SETTLE_PK) || (ph == 3 && j == peak_at);
      len[ph]++;
      if (ph == 5 && j >= 3) break;
    end
    peak = 0; comp_low = 0;
    chk(len[1] == TBL[r][2], (comp_at < 0) ? "R7" : "R6", "start phase length", len[1], TBL[r][2]);
    chk(len[2] == SETTLE + 1, "R8", "settle length with ignored peak", len[2], SETTLE + 1);
    chk(len[3] == TBL[r][3], (peak_at < 0) ? "R10" : "R9", "peak wait length", len[3], TBL[r][3]);
    chk(len[4] == TBL[r][4], "R9", "peak delay length", len[4], TBL[r][4]);
    chk(bad_ccm == 0, "R4", "ccm window mismatches", bad_ccm, 0);
    chk(bad_duty == 0, "R5", "duty ramp mismatches", bad_duty, 0);
    chk(bad_bias == 0, "R3", "bias hold mismatches", bad_bias, 0);
    chk(bad_gain == 0, "R11", "gain mode mismatches", bad_gain, 0);
    chk(bad_done == 0, "R12", "done pulse mismatches", bad_done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] held_duty;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(phase == 0, "R1", "reset phase", phase, 0);
    chk(hv_bias_en == 1, "R1", "reset bias", hv_bias_en, 1);
    chk(duty_limit == 0, "R1", "reset duty", duty_limit, 0);
    chk(!ilim_low && !freq_low && !gain_integral && !done, "R1", "reset flags", {ilim_low, freq_low, gain_integral, done}, 0);
    rst_n = 1;
    // R2: no supply, stays idle
    repeat (10) @(negedge clk);
    chk(phase == 0, "R2", "idle without supply", phase, 0);
    supply_on = 1;
    @(negedge clk);
    chk(phase == 1, "R2", "start on supply", phase, 1);
    // R13: tick gating freezes timers
    repeat (5) @(negedge clk);
    held_duty = duty_limit;
    tick = 0;
    repeat (40) @(negedge clk);
    chk(phase == 1, "R13", "phase held without tick", phase, 1);
    chk(duty_limit == held_duty, "R13", "duty held without tick", duty_limit, held_duty);
    chk(ilim_low == 1, "R13", "ccm window held without tick", ilim_low, 1);
    tick = 1;
    repeat (30) @(negedge clk);
    // R1: uvlo held mid-sequence
    uvlo = 1;
    repeat (5) @(negedge clk);
    chk(phase == 0, "R1", "idle under held uvlo", phase, 0);
    chk(hv_bias_en == 1 && duty_limit == 0, "R1", "bias and duty under uvlo", duty_limit, 0);
    uvlo = 0;
    for (int r = 0; r < NROW; r++) run_row(r);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule